// File: doc/BRIEF.md
# Single-Clock FIFO Buffer with Sticky Overflow Flag

This block is a first-in first-out queue for one clock domain. Its size is set by two parameters: `ADDR_BITS` gives the depth as `2**ADDR_BITS` entries, and `DATA_BITS` gives the width of each entry. A producer raises `push` together with `push_data` to add an entry. A consumer reads the oldest entry directly from `pop_data` and raises `pop` to remove it. Every state change happens on the rising edge of `clk`. Driving `rst_n` low, sampled at a clock edge, empties the queue.

The queue reports three status outputs: `is_full`, `is_empty` and `ovf_sticky`. `ovf_sticky` records that the producer tried to push while no entry was free. That push is discarded. The flag then stays high until the consumer removes an entry, so upstream logic can see that data was lost even if it does not sample the flag on every cycle.

Top module: `fifo_ovf_buf`

## Requirements
- R1: After a clock edge at which `rst_n` is low, `is_empty` is 1, `is_full` is 0 and `ovf_sticky` is 0.
- R2: A `push` while not full stores `push_data`. Entries leave in the order they arrived. While not empty, `pop_data` shows the oldest stored entry without any added delay.
- R3: A `pop` while not empty removes the oldest entry. A `pop` while empty is ignored: the queue stays empty and a later push is read back correctly.
- R4: The depth is `2**ADDR_BITS`. `is_full` is 1 exactly when all entries are occupied. `is_empty` is 1 exactly when none are.
- R5: A `push` while full is dropped. The stored entries, their order and the fill level are unchanged.
- R6: `ovf_sticky` goes to 1 at the edge where `push` is seen while full. It then stays 1 until the edge that accepts a `pop`, and goes to 0 at that edge.
- R7: `push` and `pop` together while neither full nor empty both take effect. The fill level is unchanged and the pushed entry joins the tail.
- R8: `push` and `pop` together while full remove the oldest entry, drop the pushed data, and set `ovf_sticky` to 1. Setting the flag takes priority over clearing it.
- R9: `push` and `pop` together while empty store the pushed entry and ignore the pop.
- R10: Reset also clears `ovf_sticky` and discards all stored entries, even when the queue was full with the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; empties the queue |
| push | input | 1 | Request to append `push_data` |
| push_data | input | DATA_BITS | Entry to be appended |
| pop | input | 1 | Request to remove the oldest entry |
| pop_data | output | DATA_BITS | Oldest stored entry (valid while not empty) |
| is_full | output | 1 | All entries occupied |
| is_empty | output | 1 | No entries occupied |
| ovf_sticky | output | 1 | Set by a push while full, cleared by the next accepted pop |

## Verification
Status results change at the first rising edge after a request: `is_full`, `is_empty` and `ovf_sticky` reflect that edge, and `pop_data` shows the new oldest entry in the same cycle with no further delay. The bench therefore drives requests at the falling edge. It checks the head entry at that falling edge, before the request takes effect, and checks the three flags at the next falling edge, after exactly one rising edge. A reference queue in the bench steps once for each rising edge, using the request and the fill level from before that edge. Directed sequences cover the full and empty corners, and a long pseudo-random sweep crosses every push/pop combination with every fill level of a four-entry queue.

// File: rtl/fifo_ovf_pkg.sv
// Package: shared types for the single-clock FIFO with sticky overflow.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package fifo_ovf_pkg;

    // Outcome of one cycle's requests after the full and empty gates.
    typedef struct packed {
        logic push_ok;    // push accepted, entry written
        logic pop_ok;     // pop accepted, head advances
        logic push_lost;  // push seen while full, entry discarded
    } xfer_t;

    // Turn raw requests and the current flags into accepted transfers.
    function automatic xfer_t grant(input logic push, input logic pop,
                                    input logic full, input logic empty);
        xfer_t g;
        g.push_ok   = push & ~full;
        g.pop_ok    = pop & ~empty;
        g.push_lost = push & full;
        return g;
    endfunction

endpackage

// File: rtl/fifo_ovf_ptr.sv
// Module: wrapping index register for one side of the FIFO.
// Does: holds an ADDR_BITS index and advances it by one when asked.
// Assumes: depth is a power of two, so wrap-around is the natural
// overflow of the index; synchronous active-low reset to entry 0.
module fifo_ovf_ptr #(
    parameter int ADDR_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 advance,
    output logic [ADDR_BITS-1:0] index
);

    // Step the index on each accepted transfer, wrapping at the depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index <= '0;
        end else if (advance) begin
            index <= index + 1'b1;
        end
    end

endmodule

// File: rtl/fifo_ovf_store.sv
// Module: register-array storage for the FIFO.
// Does: one write port clocked in on the rising edge and one read port
// that is combinational, so the head entry shows with no added delay.
// Assumes: the caller only writes to free slots; contents are not
// reset, since the fill level alone decides which slots are valid.
module fifo_ovf_store #(
    parameter int ADDR_BITS = 2,
    parameter int DATA_BITS = 4
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] wr_addr,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output logic [DATA_BITS-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_BITS;

    logic [DATA_BITS-1:0] rows [DEPTH];

    // Write the addressed row when the write is enabled.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_addr == ADDR_BITS'(i))) begin
                rows[i] <= wr_data;
            end
        end
    end

    // Present the addressed row combinationally.
    always_comb begin
        rd_data = rows[rd_addr];
    end

endmodule

// File: rtl/fifo_ovf_ctrl.sv
// Module: fill-level, flag and overflow control for the FIFO.
// Does: gates the push and pop requests against full and empty, keeps
// an ADDR_BITS+1 bit fill level, and holds the sticky overflow bit,
// which is set by a push while full and cleared by an accepted pop.
// Assumes: synchronous active-low reset; setting the overflow bit has
// priority over clearing it in the same cycle.
module fifo_ovf_ctrl
    import fifo_ovf_pkg::*;
#(
    parameter int ADDR_BITS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    output xfer_t              xfer,
    output logic [ADDR_BITS:0] level,
    output logic               full,
    output logic               empty,
    output logic               ovf
);

    localparam int CNT_W = ADDR_BITS + 1;
    localparam int DEPTH = 1 << ADDR_BITS;

    // Derive the flags from the registered fill level.
    always_comb begin
        full  = (level == CNT_W'(DEPTH));
        empty = (level == '0);
        xfer  = grant(push, pop, full, empty);
    end

    // Track how many entries are held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            case ({xfer.push_ok, xfer.pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Hold the overflow bit: set on a lost push, clear on an accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (xfer.push_lost) begin
            ovf <= 1'b1;
        end else if (xfer.pop_ok) begin
            ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/fifo_ovf_buf.sv
// Module: single-clock FIFO with full, empty and sticky overflow outputs.
// Does: joins the control unit, two index registers and the storage
// array; the head entry is read combinationally from the pop index.
// Assumes: one clock, synchronous active-low reset, depth a power of two.
module fifo_ovf_buf
    import fifo_ovf_pkg::*;
#(
    parameter int ADDR_BITS = 2,
    parameter int DATA_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [DATA_BITS-1:0] push_data,
    input  logic                 pop,
    output logic [DATA_BITS-1:0] pop_data,
    output logic                 is_full,
    output logic                 is_empty,
    output logic                 ovf_sticky
);

    xfer_t                xfer;
    logic [ADDR_BITS:0]   level;
    logic [ADDR_BITS-1:0] wr_idx;
    logic [ADDR_BITS-1:0] rd_idx;

    fifo_ovf_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .xfer  (xfer),
        .level (level),
        .full  (is_full),
        .empty (is_empty),
        .ovf   (ovf_sticky)
    );

    fifo_ovf_ptr #(.ADDR_BITS(ADDR_BITS)) u_wr_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (xfer.push_ok),
        .index   (wr_idx)
    );

    fifo_ovf_ptr #(.ADDR_BITS(ADDR_BITS)) u_rd_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (xfer.pop_ok),
        .index   (rd_idx)
    );

    fifo_ovf_store #(.ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS)) u_store (
        .clk     (clk),
        .wr_en   (xfer.push_ok),
        .wr_addr (wr_idx),
        .wr_data (push_data),
        .rd_addr (rd_idx),
        .rd_data (pop_data)
    );

endmodule

// File: rtl/fifo_ovf_buf_chk.sv
// Module: property checker for fifo_ovf_buf, attached by bind.
// Does: checks flag consistency, overflow set/hold/clear, the gating
// at the full and empty corners, and head stability.
// Assumes: the fill level is exposed by the bound instance.
module fifo_ovf_buf_chk #(
    parameter int ADDR_BITS = 2,
    parameter int DATA_BITS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 push,
    input logic                 pop,
    input logic [DATA_BITS-1:0] pop_data,
    input logic                 is_full,
    input logic                 is_empty,
    input logic                 ovf_sticky,
    input logic [ADDR_BITS:0]   occupancy
);

    // R1: a low reset at an edge leaves the queue empty with no overflow.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (is_empty && !is_full && !ovf_sticky));

    // R4: full and empty are never high together.
    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_full && is_empty));

    // R6: a push while full raises the sticky flag.
    assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full) |=> ovf_sticky);

    // R6: the flag holds while no pop is requested.
    assert_ovf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && !pop) |=> ovf_sticky);

    // R6: an accepted pop without a lost push clears the flag.
    assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && pop && !is_empty && !(push && is_full)) |=> !ovf_sticky);

    // R5: a lone push while full leaves the queue full.
    assert_full_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push && !pop) |=> (is_full && $stable(pop_data)));

    // R3: a lone pop while empty leaves the queue empty.
    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && pop && !push) |=> is_empty);

    // R2: without a pop the head entry does not change.
    assert_head_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_empty && !pop) |=> $stable(pop_data));

    // R7: push and pop together in the middle keep the fill level.
    assert_level_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !is_full && !is_empty) |=> $stable(occupancy));

    // R8: push and pop together while full leave one entry free.
    assert_full_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && is_full) |=> (!is_full && ovf_sticky));

    // R9: push and pop together while empty leave one entry held.
    assert_empty_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && is_empty) |=> (!is_empty && (occupancy == 1)));

endmodule

bind fifo_ovf_buf fifo_ovf_buf_chk #(
    .ADDR_BITS (ADDR_BITS),
    .DATA_BITS (DATA_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .pop        (pop),
    .pop_data   (pop_data),
    .is_full    (is_full),
    .is_empty   (is_empty),
    .ovf_sticky (ovf_sticky),
    .occupancy  (level)
);

// File: tb/fifo_ovf_buf_bench.sv
// Bench: directed corner sequences plus a long pseudo-random sweep of a
// four-entry, eight-bit FIFO against a reference queue kept in the bench.
module fifo_ovf_buf_bench;

    localparam int AB    = 2;
    localparam int DB    = 8;
    localparam int DEPTH = 1 << AB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push = 1'b0;
    logic          pop = 1'b0;
    logic [DB-1:0] push_data = '0;
    logic [DB-1:0] pop_data;
    logic          is_full;
    logic          is_empty;
    logic          ovf_sticky;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // Reference queue state.
    logic [DB-1:0] mq [DEPTH];
    int            mh = 0;
    int            mcnt = 0;
    logic          mov = 1'b0;

    always #4 clk = ~clk;

    fifo_ovf_buf #(.ADDR_BITS(AB), .DATA_BITS(DB)) u_fifo_ovf_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_data  (push_data),
        .pop        (pop),
        .pop_data   (pop_data),
        .is_full    (is_full),
        .is_empty   (is_empty),
        .ovf_sticky (ovf_sticky)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: check head, apply requests, step model, check flags.
    task automatic step(input logic p, input logic q, input logic [DB-1:0] d, input string tag);
        bit acc_p;
        bit acc_q;
        if (mcnt != 0) chk(32'(pop_data), 32'(mq[mh]), {tag, " R2 head"});
        push = p; pop = q; push_data = d;
        acc_p = p && (mcnt != DEPTH);
        acc_q = q && (mcnt != 0);
        if (p && (mcnt == DEPTH)) mov = 1'b1;
        else if (acc_q) mov = 1'b0;
        if (acc_p) mq[(mh + mcnt) % DEPTH] = d;
        if (acc_q) mh = (mh + 1) % DEPTH;
        mcnt = mcnt + int'(acc_p) - int'(acc_q);
        @(posedge clk);
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        chk(32'(is_full),    32'(mcnt == DEPTH), {tag, " R4 full"});
        chk(32'(is_empty),   32'(mcnt == 0),     {tag, " R4 empty"});
        chk(32'(ovf_sticky), 32'(mov),           {tag, " R6 ovf"});
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0; push = 1'b0; pop = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mh = 0; mcnt = 0; mov = 1'b0;
        chk(32'(is_empty),   32'd1, {tag, " empty"});
        chk(32'(is_full),    32'd0, {tag, " full"});
        chk(32'(ovf_sticky), 32'd0, {tag, " ovf"});
    endtask

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        do_reset("R1 reset");

        // R2 R4: fill to depth with distinct values.
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 8'hA0 + 8'(i), "R2 fill");
        // R5 R6: pushes while full are dropped, flag set and held.
        step(1'b1, 1'b0, 8'h55, "R5 push full");
        step(1'b1, 1'b0, 8'h66, "R5 push full again");
        step(1'b0, 1'b0, 8'h00, "R6 hold idle");
        // R8: both while full.
        step(1'b1, 1'b1, 8'h77, "R8 both full");
        // R6: next pop clears the flag.
        step(1'b0, 1'b1, 8'h00, "R6 clear");
        // R7: both in the middle.
        step(1'b1, 1'b1, 8'h31, "R7 both mid");
        step(1'b1, 1'b1, 8'h32, "R7 both mid 2");
        // R3 R5: drain, checking order; then pop while empty.
        while (mcnt != 0) step(1'b0, 1'b1, 8'h00, "R3 drain");
        step(1'b0, 1'b1, 8'h00, "R3 pop empty");
        step(1'b0, 1'b1, 8'h00, "R3 pop empty again");
        // R9: both while empty.
        step(1'b1, 1'b1, 8'hC9, "R9 both empty");
        step(1'b0, 1'b1, 8'h00, "R9 read back");
        // R10: reset from full with overflow set.
        for (int i = 0; i < DEPTH + 1; i++) step(1'b1, 1'b0, 8'hE0 + 8'(i), "R10 prefill");
        do_reset("R10 reset");
        step(1'b1, 1'b0, 8'h5A, "R10 after reset");
        step(1'b0, 1'b1, 8'h00, "R10 read back");

        // Sweep: pseudo-random requests over all fill levels.
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            logic p;
            logic q;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            // Bias phases toward filling or draining to reach the corners.
            case ((i / 64) % 3)
                0:       begin p = lfsr[0] | lfsr[1]; q = lfsr[2] & lfsr[3]; end
                1:       begin p = lfsr[0] & lfsr[1]; q = lfsr[2] | lfsr[3]; end
                default: begin p = lfsr[0];           q = lfsr[5];           end
            endcase
            step(p, q, lfsr[15:8], "R7 R8 R9 sweep");
            if ((i % 1500) == 1499) do_reset("R1 sweep reset");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule